// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block holds the digital control for a successive-approximation converter. An asynchronous SAMPLE strobe and an asynchronous conversion clock both arrive from outside. The block brings them into its own system clock domain and detects their edges. While SAMPLE is high, the track switch is closed and the input is followed. When SAMPLE falls, the block commits to a conversion: it opens the switch, raises BUSY and waits out a settling window.

After the window, the block counts rising edges of the conversion clock. Sixteen of them decide the code one bit at a time, from MSB to LSB. Each decision uses the comparator input, which reports whether the DAC voltage exceeds the held input. The seventeenth edge copies the finished code into the output register and drops BUSY. From that point the result stays readable until the next conversion ends.

While a conversion runs, further SAMPLE edges are ignored. Conversion clock edges are ignored in three places: outside a conversion, during the settling window, and once BUSY is low.

Top module: `sar_conv_seq`

## Requirements
- R1: `track_en` is 1 exactly when no conversion is running (`busy`=0) and the synchronised SAMPLE level is 1. A change on `sample_in` reaches the synchronised level after SYNC_STAGES system clocks.
- R2: A falling edge on the synchronised SAMPLE while idle starts a conversion. `busy` goes to 1 SYNC_STAGES+1 system clocks after `sample_in` falls.
- R3: A conversion uses exactly 17 counted rising edges of `cclk_in`. After 16 counted edges `busy` is still 1.
- R4: Rising edges of `cclk_in` detected during the SETTLE_CYC system clocks that follow the start of a conversion are not counted.
- R5: `busy` falls in the same system clock in which `data_out` takes the new result.
- R6: While `busy` is 0, rising edges of `cclk_in` have no effect, and `data_out` changes only at the end of a conversion.
- R7: A SAMPLE falling edge that is detected while `busy` is 1 is ignored and does not start a later conversion. This includes a fall detected in the cycle that completes a conversion.
- R8: A synchronous reset (`rst`=1) makes `busy` 0, aborts any conversion and sets `data_out` and `dac_code` to 0.
- R9: When settling ends, `dac_code` holds only its MSB set. On each counted edge k (k=0..15), bit 15-k is cleared if `cmp_in`=1 (DAC above input), and then bit 14-k is set. With an ideal comparator the result therefore equals the held input code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 1 | Asynchronous sample strobe; high tracks, falling edge commits |
| cclk_in | input | 1 | Asynchronous conversion clock |
| cmp_in | input | 1 | Comparator: 1 when the DAC level exceeds the held input |
| track_en | output | 1 | Track/hold switch control, 1 = tracking |
| dac_code | output | DATA_W | Trial code driven to the capacitor DAC |
| data_out | output | DATA_W | Last completed conversion result |
| busy | output | 1 | Conversion in progress |

## Verification
Two functions can fall in the same system cycle: the end of a conversion on the seventeenth counted clock, and a new SAMPLE commit. The bench provokes this by driving the seventeenth conversion clock rise and the SAMPLE fall at the same instant, so that both pass the equal-depth synchronisers together. A cycle-by-cycle behavioural model judges the outcome. It expects the fall to be discarded, `data_out` to take the result and `busy` to stay low afterwards. Separate scenarios place conversion clock edges inside the settling window and after completion, and toggle SAMPLE in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    // synchronised level plus its value one system clock earlier
    typedef struct packed {
        logic level;
        logic prev;
    } sync_pair_t;

    function automatic logic rise_of(input sync_pair_t p);
        return p.level & ~p.prev;
    endfunction

    function automatic logic fall_of(input sync_pair_t p);
        return p.prev & ~p.level;
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync
    import sar_seq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output sync_pair_t sp
);
    logic synced;
    logic prev_q;

    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b0;
                else     s_q <= din;
            end
            assign synced = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
            assign synced = sh_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= synced;
    end

    assign sp.level = synced;
    assign sp.prev  = prev_q;
endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= CNT_W'(SETTLE_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step_en,
    input  logic              cmp,
    output logic [DATA_W-1:0] code,
    output logic              last
);
    localparam int STEP_W = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [STEP_W-1:0] step_q;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] cur_mask;
    logic [DATA_W-1:0] next_mask;
    logic [DATA_W-1:0] code_n;

    always_comb begin
        cur_mask  = MSB_MASK >> step_q;
        next_mask = cur_mask >> 1;
        code_n    = (code_q & ~(cmp ? cur_mask : '0)) | next_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            code_q <= '0;
        end else if (load) begin
            step_q <= '0;
            code_q <= MSB_MASK;
        end else if (step_en && !last) begin
            step_q <= step_q + 1'b1;
            code_q <= code_n;
        end
    end

    assign code = code_q;
    assign last = (step_q == STEP_W'(DATA_W));

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        step_q <= STEP_W'(DATA_W)); // R3
    AST_DECIDED_BIT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (step_en && !last && !load && !cmp) |=> ((code_q & $past(cur_mask)) != '0)); // R9
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_in,
    input  logic              cclk_in,
    input  logic              cmp_in,
    output logic              track_en,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] data_out,
    output logic              busy
);
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    sync_pair_t smp_sp;
    sync_pair_t ck_sp;
    logic       smp_fall;
    logic       ck_rise;
    logic       tmr_done;
    logic       eng_last;
    logic       commit;
    logic       finish;
    logic       eng_load;
    logic       eng_step;
    seq_state_e state_q;
    seq_state_e state_n;
    logic [DATA_W-1:0] data_q;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) i_smp_sync (
        .clk(clk), .rst(rst), .din(sample_in), .sp(smp_sp));
    sar_edge_sync #(.STAGES(SYNC_STAGES)) i_ck_sync (
        .clk(clk), .rst(rst), .din(cclk_in), .sp(ck_sp));

    assign smp_fall = fall_of(smp_sp);
    assign ck_rise  = rise_of(ck_sp);

    assign commit   = (state_q == ST_IDLE) && smp_fall;
    assign eng_load = (state_q == ST_SETTLE) && tmr_done;
    assign eng_step = (state_q == ST_CONV) && ck_rise && !eng_last;
    assign finish   = (state_q == ST_CONV) && ck_rise && eng_last;

    sar_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
        .clk(clk), .rst(rst), .start(commit), .done(tmr_done));

    sar_bit_engine #(.DATA_W(DATA_W)) i_engine (
        .clk(clk), .rst(rst), .load(eng_load), .step_en(eng_step),
        .cmp(cmp_in), .code(dac_code), .last(eng_last));

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (commit)   state_n = ST_SETTLE;
            ST_SETTLE: if (tmr_done) state_n = ST_CONV;
            ST_CONV:   if (finish)   state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            if (finish) data_q <= dac_code;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign track_en = (state_q == ST_IDLE) && smp_sp.level;
    assign data_out = data_q;

    AST_TRACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        track_en |-> !busy); // R1
    AST_COMMIT_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && smp_fall) |=> busy); // R2
    AST_SETTLE_FREEZES_CODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && !tmr_done) |=> $stable(dac_code)); // R4
    AST_BUSY_FALL_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (data_out == dac_code)); // R5
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(data_out)); // R6
    AST_SAMPLE_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && smp_fall && !finish) |=> busy); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy && data_out == '0 && dac_code == '0)); // R8
    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        eng_load |=> (dac_code == MSB_ONLY)); // R9
endmodule

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
    localparam int W      = 16;
    localparam int STG    = 2;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_in = 1'b0;
    logic cclk_in = 1'b0;
    logic [W-1:0] vin = '0;
    logic track_en, busy;
    logic [W-1:0] dac_code, data_out;
    logic cmp_in;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign cmp_in = (dac_code > vin);

    sar_conv_seq #(.DATA_W(W), .SYNC_STAGES(STG), .SETTLE_CYC(SETTLE)) i_sar_conv_seq (
        .clk(clk), .rst(rst), .sample_in(sample_in), .cclk_in(cclk_in),
        .cmp_in(cmp_in), .track_en(track_en), .dac_code(dac_code),
        .data_out(data_out), .busy(busy));

    // behavioural reference model
    int   sq[$];
    int   cq[$];
    int   m_phase;
    int   m_cnt;
    int   m_step;
    logic [W-1:0] m_code;
    logic [W-1:0] m_data;
    logic m_track;

    task automatic model_clear();
        sq = {}; cq = {};
        for (int i = 0; i <= STG; i++) begin sq.push_back(0); cq.push_back(0); end
        m_phase = 0; m_cnt = 0; m_step = 0; m_code = '0; m_data = '0; m_track = 1'b0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (rst) begin
            model_clear();
        end else begin
            bit s_fall, c_rise;
            s_fall = (sq[STG] == 1) && (sq[STG-1] == 0);
            c_rise = (cq[STG-1] == 1) && (cq[STG] == 0);
            if (m_phase == 0) begin
                if (s_fall) begin m_phase = 1; m_cnt = SETTLE; end
            end else if (m_phase == 1) begin
                if (m_cnt == 1) begin m_phase = 2; m_step = 0; m_code = '0; m_code[W-1] = 1'b1; end
                m_cnt = m_cnt - 1;
            end else if (c_rise) begin
                if (m_step == W) begin
                    m_data = m_code; m_phase = 0;
                end else begin
                    int b;
                    b = W - 1 - m_step;
                    if (m_code > vin) m_code[b] = 1'b0;
                    if (b > 0) m_code[b-1] = 1'b1;
                    m_step++;
                end
            end
            sq.push_front(int'(sample_in)); void'(sq.pop_back());
            cq.push_front(int'(cclk_in));   void'(cq.pop_back());
            m_track = (m_phase == 0) && (sq[STG-1] == 1);
        end
    end

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R1", "track_en", W'(track_en), W'(m_track));
            check("R2", "busy", W'(busy), W'(m_phase != 0));
            check("R9", "dac_code", dac_code, m_code);
            check("R6", "data_out", data_out, m_data);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cclk_in = 1'b1; idle(2);
            @(negedge clk); cclk_in = 1'b0; idle(2);
        end
    endtask

    task automatic start_conv(input logic [W-1:0] v);
        vin = v;
        @(negedge clk); sample_in = 1'b1;
        idle(5);
        check("R1", "tracking while SAMPLE high", W'(track_en), W'(1));
        @(negedge clk); sample_in = 1'b0;
    endtask

    task automatic full_conv(input logic [W-1:0] v, input string req);
        start_conv(v);
        idle(SETTLE + 8);
        pulses(16);
        check("R3", "busy after 16 clocks", W'(busy), W'(1));
        pulses(1);
        idle(2);
        check("R5", "busy low after 17th clock", W'(busy), W'(0));
        check(req, "result", data_out, v);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "busy after reset", W'(busy), W'(0));
        check("R8", "data after reset", data_out, '0);
        check("R8", "dac after reset", dac_code, '0);

        // plain conversion
        full_conv(16'hA5C3, "R9");

        // clocks while idle are ignored
        pulses(5);
        idle(3);
        check("R6", "data held after extra clocks", data_out, 16'hA5C3);
        check("R6", "busy stays low", W'(busy), W'(0));

        // early clocks inside settling window
        start_conv(16'h1234);
        idle(3);
        check("R2", "busy after commit", W'(busy), W'(1));
        pulses(1);
        idle(SETTLE);
        pulses(16);
        check("R4", "early clock not counted", W'(busy), W'(1));
        check("R6", "old data during conversion", data_out, 16'hA5C3);
        pulses(1);
        idle(2);
        check("R4", "result after early clock", data_out, 16'h1234);

        // SAMPLE toggled mid-conversion
        start_conv(16'hFFFF);
        idle(SETTLE + 8);
        pulses(8);
        @(negedge clk); sample_in = 1'b1; idle(4);
        @(negedge clk); sample_in = 1'b0; idle(4);
        pulses(9);
        idle(2);
        check("R7", "result with sample toggles", data_out, 16'hFFFF);
        idle(30);
        check("R7", "no second conversion", W'(busy), W'(0));

        // boundaries
        full_conv(16'h0000, "R9");
        full_conv(16'h8000, "R9");
        full_conv(16'h7FFF, "R9");

        // SAMPLE fall coincides with the completing clock
        start_conv(16'h5A5A);
        idle(SETTLE + 8);
        pulses(16);
        @(negedge clk); sample_in = 1'b1; idle(4);
        @(negedge clk); cclk_in = 1'b1; sample_in = 1'b0; idle(2);
        @(negedge clk); cclk_in = 1'b0; idle(3);
        check("R5", "completed on shared cycle", data_out, 16'h5A5A);
        idle(30);
        check("R7", "fall at completion ignored", W'(busy), W'(0));

        // reset mid-conversion
        start_conv(16'h0F0F);
        idle(SETTLE + 8);
        pulses(5);
        @(negedge clk); rst = 1'b1; idle(2);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R8", "busy after mid reset", W'(busy), W'(0));
        check("R8", "data after mid reset", data_out, '0);

        full_conv(16'h3C3C, "R3");
        idle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule